// File: doc/BRIEF.md
# TDMA Communication-Cycle Scheduler with Minislots

This block keeps the communication cycle of a node on a time-triggered bus. The fast local clock is the microtick. A divider turns it into macroticks of a configurable number of microticks. Each cycle has three phases in a fixed order:

- a static phase of equal, fixed-length slots;
- a dynamic phase made of minislots that are visited in priority order;
- a quiet idle tail.

The node owns one ID, and that ID applies both to a static slot and to a minislot. The block raises its transmit enable for the whole of the node's static slot. In the dynamic phase it does so only when data is pending and the frame fits in the budget that is left.

A minislot whose owner is silent lasts a single macrotick. A minislot that carries a frame is stretched to the frame length plus one gap macrotick. The following minislot begins directly after either kind. The host sees four outputs: the phase, the current slot or minislot index, a macrotick strobe and a one-clock cycle-start strobe. All configuration inputs must be held stable while the block runs out of reset.

Top module: `tdma_cycle_sched`

## Requirements
- R1: `mt_tick` is high for exactly one clock in every `cfg_ut_per_mt` clocks, on the last microtick of each macrotick; the first macrotick starts on the first clock after the internal reset release.
- R2: The static phase holds `cfg_static_slots` slots of `cfg_mt_per_slot` macroticks each; `slot_idx` counts them 0, 1, 2 and so on.
- R3: In the static phase `tx_en` is high exactly during the slot whose index equals `cfg_node_id`.
- R4: The dynamic phase visits minislot indices 0, 1, 2 and so on in order; a minislot whose index is not the node ID, or whose owner has nothing to send, lasts exactly 1 macrotick.
- R5: If, when the node's minislot begins, `tx_pending` is 1 and `tx_frame_len` is F with F > 0, and F+1 does not exceed the macroticks left in the dynamic phase, then that minislot lasts F+1 macroticks and `tx_en` is high for its first F macroticks.
- R6: Transmission in the node's minislot is dropped, and the minislot lasts 1 macrotick, when F is 0, when `tx_pending` is 0, or when F+1 exceeds the macroticks left in the dynamic phase (the current one included).
- R7: The dynamic phase lasts exactly `cfg_dyn_len` macroticks. Once all `cfg_minislots` minislots have been used, `slot_idx` equals `cfg_minislots` and `tx_en` stays low until the phase ends.
- R8: `seg` reads 2'b00 in the static phase, 2'b01 in the dynamic phase and 2'b10 in the idle phase. The idle phase lasts `cfg_idle_len` macroticks, with `slot_idx` at 0 and `tx_en` low.
- R9: `cycle_start` is high for one clock, on the first microtick of every cycle, while `seg` is static and `slot_idx` is 0.
- R10: While reset is asserted, `seg` is static, `slot_idx` is 0 and `cycle_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microtick clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_ut_per_mt | input | UTW | Microticks per macrotick, at least 1 |
| cfg_mt_per_slot | input | MTW | Macroticks per static slot, at least 1 |
| cfg_static_slots | input | IDW | Number of static slots, at least 1 |
| cfg_node_id | input | IDW | Slot and minislot index owned by this node |
| cfg_minislots | input | IDW | Number of minislots, at least 1 |
| cfg_dyn_len | input | MTW | Dynamic phase length in macroticks, at least 1 |
| cfg_idle_len | input | MTW | Idle phase length in macroticks, at least 1 |
| tx_pending | input | 1 | Node has a dynamic frame to send |
| tx_frame_len | input | FLW | Dynamic frame length in macroticks |
| mt_tick | output | 1 | Last microtick of a macrotick |
| seg | output | 2 | Current phase code |
| slot_idx | output | IDW | Current slot or minislot index |
| tx_en | output | 1 | Transmit enable for this node |
| cycle_start | output | 1 | One-clock strobe at the start of each cycle |

## Verification
The hardest case to reach from the ports is a node minislot that begins with almost no dynamic budget left. It has to hit both the exact fit (F+1 equal to the remaining macroticks, so the dynamic phase ends inside the stretched minislot) and the overrun by one that must be dropped. Directed configurations place the node ID and the frame length so that both boundaries occur in the first cycle. Random configurations with a fixed seed then vary the phase lengths and the node ID, and draw a new pending flag and frame length during each idle phase.

The bench model lays out every macrotick of a cycle from the configuration and the latched request. It compares all outputs on every clock.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  typedef enum logic [1:0] {
    SEG_STATIC = 2'b00,
    SEG_DYN    = 2'b01,
    SEG_IDLE   = 2'b10
  } seg_e;
endpackage

// File: rtl/tdma_mt_div.sv
module tdma_mt_div #(
  parameter int UTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [UTW-1:0] cfg_ut_per_mt,
  output logic           mt_tick
);
  logic [UTW-1:0] ut_cnt_q;
  logic [UTW-1:0] ut_cnt_d;
  logic           last_ut;

  assign last_ut = (ut_cnt_q >= cfg_ut_per_mt - 1'b1);
  assign mt_tick = last_ut;

  always_comb begin
    if (last_ut) ut_cnt_d = '0;
    else         ut_cnt_d = ut_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ut_cnt_q <= '0;
    else        ut_cnt_q <= ut_cnt_d;
  end

  // R1: the microtick count never leaves the configured macrotick range
  p_ut_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ut_cnt_q < cfg_ut_per_mt);
endmodule

// File: rtl/tdma_ms_grant.sv
module tdma_ms_grant #(
  parameter int MTW = 12,
  parameter int IDW = 6,
  parameter int FLW = 8
) (
  input  logic [IDW-1:0] ms_idx,
  input  logic [IDW-1:0] node_id,
  input  logic           pending,
  input  logic [FLW-1:0] frame_len,
  input  logic [MTW-1:0] remaining,
  output logic           used,
  output logic [MTW-1:0] ms_len
);
  localparam int PADW = MTW - FLW;
  localparam logic [MTW-1:0] ONE_MT = {{(MTW-1){1'b0}}, 1'b1};

  logic [MTW-1:0] full_len;
  logic           fits;

  assign full_len = {{PADW{1'b0}}, frame_len} + 1'b1;
  assign fits     = (full_len <= remaining);
  assign used     = pending && (ms_idx == node_id) && (frame_len != '0) && fits;
  assign ms_len   = used ? full_len : ONE_MT;
endmodule

// File: rtl/tdma_seg_seq.sv
module tdma_seg_seq
  import tdma_pkg::*;
#(
  parameter int MTW = 12,
  parameter int IDW = 6,
  parameter int FLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mt_tick,
  input  logic [MTW-1:0] cfg_mt_per_slot,
  input  logic [IDW-1:0] cfg_static_slots,
  input  logic [IDW-1:0] cfg_node_id,
  input  logic [IDW-1:0] cfg_minislots,
  input  logic [MTW-1:0] cfg_dyn_len,
  input  logic [MTW-1:0] cfg_idle_len,
  input  logic           tx_pending,
  input  logic [FLW-1:0] tx_frame_len,
  output seg_e           seg_o,
  output logic [IDW-1:0] idx_o,
  output logic [MTW-1:0] mt_cnt_o,
  output logic           ms_used_o,
  output logic [MTW-1:0] ms_len_o,
  output logic           cycle_start_o
);
  localparam logic [MTW-1:0] ONE_MT = {{(MTW-1){1'b0}}, 1'b1};

  seg_e           seg_q, seg_d;
  logic [IDW-1:0] idx_q, idx_d;
  logic [MTW-1:0] mt_cnt_q, mt_cnt_d;
  logic           used_q, used_d;
  logic [MTW-1:0] len_q, len_d;
  logic [MTW-1:0] left_q, left_d;
  logic           cs_q, cs_d;

  logic [IDW-1:0] g_idx;
  logic [MTW-1:0] g_rem;
  logic           g_used;
  logic [MTW-1:0] g_len;
  logic [IDW-1:0] idx_inc;

  assign idx_inc = idx_q + 1'b1;
  assign g_idx   = (seg_q == SEG_STATIC) ? '0 : idx_inc;
  assign g_rem   = (seg_q == SEG_STATIC) ? cfg_dyn_len : (left_q - 1'b1);

  tdma_ms_grant #(.MTW(MTW), .IDW(IDW), .FLW(FLW)) u_grant (
    .ms_idx    (g_idx),
    .node_id   (cfg_node_id),
    .pending   (tx_pending),
    .frame_len (tx_frame_len),
    .remaining (g_rem),
    .used      (g_used),
    .ms_len    (g_len)
  );

  always_comb begin
    seg_d    = seg_q;
    idx_d    = idx_q;
    mt_cnt_d = mt_cnt_q;
    used_d   = used_q;
    len_d    = len_q;
    left_d   = left_q;
    cs_d     = 1'b0;
    unique case (seg_q)
      SEG_STATIC: begin
        if (mt_cnt_q == cfg_mt_per_slot - 1'b1) begin
          mt_cnt_d = '0;
          if (idx_q == cfg_static_slots - 1'b1) begin
            seg_d  = SEG_DYN;
            idx_d  = '0;
            left_d = cfg_dyn_len;
            used_d = g_used;
            len_d  = g_len;
          end else begin
            idx_d = idx_inc;
          end
        end else begin
          mt_cnt_d = mt_cnt_q + 1'b1;
        end
      end
      SEG_DYN: begin
        left_d = left_q - 1'b1;
        if (left_q == ONE_MT) begin
          seg_d    = SEG_IDLE;
          idx_d    = '0;
          mt_cnt_d = '0;
          used_d   = 1'b0;
          len_d    = ONE_MT;
        end else if (idx_q < cfg_minislots) begin
          if (mt_cnt_q == len_q - 1'b1) begin
            mt_cnt_d = '0;
            idx_d    = idx_inc;
            if (idx_inc < cfg_minislots) begin
              used_d = g_used;
              len_d  = g_len;
            end else begin
              used_d = 1'b0;
              len_d  = ONE_MT;
            end
          end else begin
            mt_cnt_d = mt_cnt_q + 1'b1;
          end
        end
      end
      SEG_IDLE: begin
        if (mt_cnt_q == cfg_idle_len - 1'b1) begin
          seg_d    = SEG_STATIC;
          idx_d    = '0;
          mt_cnt_d = '0;
          cs_d     = mt_tick;
        end else begin
          mt_cnt_d = mt_cnt_q + 1'b1;
        end
      end
      default: begin
        seg_d    = SEG_STATIC;
        idx_d    = '0;
        mt_cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= SEG_STATIC;
      idx_q    <= '0;
      mt_cnt_q <= '0;
      used_q   <= 1'b0;
      len_q    <= ONE_MT;
      left_q   <= '0;
    end else if (mt_tick) begin
      seg_q    <= seg_d;
      idx_q    <= idx_d;
      mt_cnt_q <= mt_cnt_d;
      used_q   <= used_d;
      len_q    <= len_d;
      left_q   <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_d;
  end

  assign seg_o         = seg_q;
  assign idx_o         = idx_q;
  assign mt_cnt_o      = mt_cnt_q;
  assign ms_used_o     = used_q;
  assign ms_len_o      = len_q;
  assign cycle_start_o = cs_q;

  // R2: static slot index stays below the configured slot count
  p_static_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_STATIC) |-> (idx_q < cfg_static_slots));

  // R4: a finished minislot hands over to the next index
  p_minislot_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_tick && seg_q == SEG_DYN && left_q != ONE_MT && idx_q < cfg_minislots
     && mt_cnt_q == len_q - 1'b1) |=> (idx_q == $past(idx_q) + 1'b1));

  // R6: a granted minislot always fits inside the dynamic budget
  p_dyn_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_DYN && used_q) |->
      ({1'b0, len_q} <= {1'b0, left_q} + {1'b0, mt_cnt_q}));

  // R9: cycle start lasts a single clock
  p_cycle_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> !cs_q);

  // R9: cycle start coincides with the very first static slot
  p_cycle_start_slot0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> (seg_q == SEG_STATIC && idx_q == '0 && mt_cnt_q == '0));
endmodule

// File: rtl/tdma_tx_gate.sv
module tdma_tx_gate
  import tdma_pkg::*;
#(
  parameter int MTW = 12,
  parameter int IDW = 6
) (
  input  seg_e           seg,
  input  logic [IDW-1:0] idx,
  input  logic [IDW-1:0] node_id,
  input  logic           ms_used,
  input  logic [MTW-1:0] mt_cnt,
  input  logic [MTW-1:0] ms_len,
  output logic           tx_en
);
  logic own;
  logic static_tx;
  logic dyn_tx;

  assign own       = (idx == node_id);
  assign static_tx = (seg == SEG_STATIC) && own;
  assign dyn_tx    = (seg == SEG_DYN) && own && ms_used && (mt_cnt < ms_len - 1'b1);
  assign tx_en     = static_tx || dyn_tx;
endmodule

// File: rtl/tdma_cycle_sched.sv
module tdma_cycle_sched
  import tdma_pkg::*;
#(
  parameter int UTW = 8,
  parameter int MTW = 12,
  parameter int IDW = 6,
  parameter int FLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [UTW-1:0] cfg_ut_per_mt,
  input  logic [MTW-1:0] cfg_mt_per_slot,
  input  logic [IDW-1:0] cfg_static_slots,
  input  logic [IDW-1:0] cfg_node_id,
  input  logic [IDW-1:0] cfg_minislots,
  input  logic [MTW-1:0] cfg_dyn_len,
  input  logic [MTW-1:0] cfg_idle_len,
  input  logic           tx_pending,
  input  logic [FLW-1:0] tx_frame_len,
  output logic           mt_tick,
  output logic [1:0]     seg,
  output logic [IDW-1:0] slot_idx,
  output logic           tx_en,
  output logic           cycle_start
);
  logic           rst_s1, rst_i;
  seg_e           seg_w;
  logic [MTW-1:0] mt_cnt_w;
  logic           ms_used_w;
  logic [MTW-1:0] ms_len_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  tdma_mt_div #(.UTW(UTW)) u_div (
    .clk           (clk),
    .rst_n         (rst_i),
    .cfg_ut_per_mt (cfg_ut_per_mt),
    .mt_tick       (mt_tick)
  );

  tdma_seg_seq #(.MTW(MTW), .IDW(IDW), .FLW(FLW)) u_seq (
    .clk              (clk),
    .rst_n            (rst_i),
    .mt_tick          (mt_tick),
    .cfg_mt_per_slot  (cfg_mt_per_slot),
    .cfg_static_slots (cfg_static_slots),
    .cfg_node_id      (cfg_node_id),
    .cfg_minislots    (cfg_minislots),
    .cfg_dyn_len      (cfg_dyn_len),
    .cfg_idle_len     (cfg_idle_len),
    .tx_pending       (tx_pending),
    .tx_frame_len     (tx_frame_len),
    .seg_o            (seg_w),
    .idx_o            (slot_idx),
    .mt_cnt_o         (mt_cnt_w),
    .ms_used_o        (ms_used_w),
    .ms_len_o         (ms_len_w),
    .cycle_start_o    (cycle_start)
  );

  tdma_tx_gate #(.MTW(MTW), .IDW(IDW)) u_gate (
    .seg     (seg_w),
    .idx     (slot_idx),
    .node_id (cfg_node_id),
    .ms_used (ms_used_w),
    .mt_cnt  (mt_cnt_w),
    .ms_len  (ms_len_w),
    .tx_en   (tx_en)
  );

  assign seg = seg_w;

  // R8: the idle phase never transmits
  p_no_tx_idle_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (seg == 2'b10) |-> !tx_en);
endmodule

// File: tb/tb_tdma_cycle_sched.sv
module tb_tdma_cycle_sched;
  localparam int UTW = 8;
  localparam int MTW = 12;
  localparam int IDW = 6;
  localparam int FLW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [UTW-1:0] cfg_ut_per_mt = 8'd1;
  logic [MTW-1:0] cfg_mt_per_slot = 12'd1;
  logic [IDW-1:0] cfg_static_slots = 6'd1;
  logic [IDW-1:0] cfg_node_id = 6'd0;
  logic [IDW-1:0] cfg_minislots = 6'd1;
  logic [MTW-1:0] cfg_dyn_len = 12'd1;
  logic [MTW-1:0] cfg_idle_len = 12'd1;
  logic tx_pending = 1'b0;
  logic [FLW-1:0] tx_frame_len = '0;
  logic mt_tick, tx_en, cycle_start;
  logic [1:0] seg;
  logic [IDW-1:0] slot_idx;

  int checks = 0;
  int errors = 0;
  int r, p, ns, id, nm, dyn, idle, fl;
  bit pend;

  always #5 clk = ~clk;

  tdma_cycle_sched #(.UTW(UTW), .MTW(MTW), .IDW(IDW), .FLW(FLW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_ut_per_mt(cfg_ut_per_mt), .cfg_mt_per_slot(cfg_mt_per_slot),
    .cfg_static_slots(cfg_static_slots), .cfg_node_id(cfg_node_id),
    .cfg_minislots(cfg_minislots), .cfg_dyn_len(cfg_dyn_len),
    .cfg_idle_len(cfg_idle_len), .tx_pending(tx_pending),
    .tx_frame_len(tx_frame_len), .mt_tick(mt_tick), .seg(seg),
    .slot_idx(slot_idx), .tx_en(tx_en), .cycle_start(cycle_start)
  );

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // expected phase, index and enable for macrotick m of a cycle
  function automatic void exp_at(input int m, output int es, output int ei, output int et);
    int d, pos, len;
    bit used;
    if (m < ns * p) begin
      es = 0; ei = m / p; et = (ei == id) ? 1 : 0;
      return;
    end
    d = m - ns * p;
    if (d < dyn) begin
      es = 1; pos = 0;
      for (int k = 0; k < nm; k++) begin
        used = (k == id) && pend && (fl != 0) && (fl + 1 <= dyn - pos);
        len = used ? fl + 1 : 1;
        if (d < pos + len) begin
          ei = k; et = (used && (d - pos < fl)) ? 1 : 0;
          return;
        end
        pos += len;
      end
      ei = nm; et = 0;   // R7 tail after the last minislot
      return;
    end
    es = 2; ei = 0; et = 0;
  endfunction

  task automatic run_cfg(input int r_i, p_i, ns_i, id_i, nm_i, dyn_i, idle_i,
                         input bit pend_i, input int fl_i, input int ncyc, input bit rnd);
    int ut, m, cl, es, ei, et;
    string itag, ttag;
    @(negedge clk);
    rst_n = 1'b0;
    r = r_i; p = p_i; ns = ns_i; id = id_i; nm = nm_i; dyn = dyn_i; idle = idle_i;
    pend = pend_i; fl = fl_i;
    cfg_ut_per_mt = UTW'(r); cfg_mt_per_slot = MTW'(p); cfg_static_slots = IDW'(ns);
    cfg_node_id = IDW'(id); cfg_minislots = IDW'(nm); cfg_dyn_len = MTW'(dyn);
    cfg_idle_len = MTW'(idle); tx_pending = pend; tx_frame_len = FLW'(fl);
    @(negedge clk); @(negedge clk);
    chk(int'(seg), 0, "R10", "reset seg");
    chk(int'(slot_idx), 0, "R10", "reset slot_idx");
    chk(int'(cycle_start), 1, "R10", "reset cycle_start");
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    cl = ns * p + dyn + idle;
    ut = 0; m = 0;
    for (int c = 0; c < ncyc * cl * r; c++) begin
      @(negedge clk);
      exp_at(m, es, ei, et);
      chk(int'(mt_tick), (ut == r - 1) ? 1 : 0, "R1", "mt_tick");
      chk(int'(cycle_start), (m == 0 && ut == 0) ? 1 : 0, "R9", "cycle_start");
      chk(int'(seg), es, "R8", "seg");
      itag = (es == 0) ? "R2" : (es == 2) ? "R8" : (ei == nm) ? "R7" : "R4";
      chk(int'(slot_idx), ei, itag, "slot_idx");
      ttag = (es == 0) ? "R3" : (es == 2) ? "R8" : "R5/R6";
      chk(int'(tx_en), et, ttag, "tx_en");
      if (rnd && es == 2 && ut == 0 && m == ns * p + dyn) begin
        pend = 1'($urandom_range(0, 3) != 0);
        fl = $urandom_range(0, 8);
        tx_pending = pend; tx_frame_len = FLW'(fl);
      end
      ut++;
      if (ut == r) begin
        ut = 0; m++;
        if (m == cl) m = 0;
      end
    end
  endtask

  initial begin
    int n = 0;
    forever begin
      @(posedge clk);
      n++;
      if (n >= 200000) begin
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R5 node minislot stretched, r of 1
    run_cfg(1, 1, 2, 1, 3, 6, 1, 1'b1, 3, 2, 1'b0);
    // R5 exact fit: frame plus gap equals the remaining budget
    run_cfg(2, 2, 2, 1, 3, 5, 2, 1'b1, 3, 2, 1'b0);
    // R6 overrun by one is dropped, R7 tail index
    run_cfg(2, 1, 3, 1, 3, 5, 1, 1'b1, 4, 2, 1'b0);
    // R6 zero frame length with pending set
    run_cfg(3, 2, 2, 0, 4, 8, 2, 1'b1, 0, 2, 1'b0);
    // R4 node in last minislot, R3 owner in static
    run_cfg(1, 3, 4, 3, 4, 10, 3, 1'b1, 2, 2, 1'b0);
    // R3 ID beyond every slot: never transmits
    run_cfg(2, 2, 2, 9, 3, 6, 1, 1'b1, 2, 2, 1'b0);
    for (int k = 0; k < 12; k++) begin
      int nmr;
      nmr = $urandom_range(1, 6);
      run_cfg($urandom_range(1, 3), $urandom_range(1, 3), $urandom_range(1, 4),
              $urandom_range(0, nmr), nmr, $urandom_range(1, 16), $urandom_range(1, 3),
              1'($urandom_range(0, 1)), $urandom_range(0, 8), 3, 1'b1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule